// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block picks the one interrupt input, out of a small power-of-two group (eight by default), that should be presented to the processor next. Each cycle it takes four inputs. The first is the pending vector. The second is the mask vector. The third is the in-service vector. The fourth is a rotation base that decides which input currently holds the top rank.

An input is a candidate when it is pending and not masked. The best candidate wins only if it ranks strictly above every input already in service. The winner's absolute index and a valid flag are registered, so they appear one clock after the inputs that produced them.

Ranks are measured from the base. The input equal to the base has rank 0, which is the highest, and the ranks climb as the index walks upward and wraps around. For cascaded use, the instance built as the master can drop the cascade input from the in-service comparison while the nesting mode input is high. This lets a second request from the downstream controller pass through while an earlier one from that controller is still in service. Latching of request edges, register access from software and the commands that move the base all sit outside this block.

Top module: `rot_prio_resolver`

## Requirements
- R1: While rst_ni is low, and on the first output after reset, req_valid_o is 0 and req_idx_o is 0.
- R2: An input is a candidate only when its bit in pend_i is 1 and its bit in mask_i is 0; a masked input is never returned.
- R3: The rank of input i is (i - base_i) mod N, where rank 0 is the highest. Among the candidates, the one with the lowest rank wins.
- R4: req_idx_o carries the absolute input number of the winner, that is (rank + base_i) mod N, and not its rank.
- R5: A request is raised only when the winner's rank is strictly lower than the lowest rank among the in-service bits; an in-service input of equal or higher priority suppresses it.
- R6: In the master build (IS_MASTER=1), when nest_i is 1, in-service bit CASCADE_IDX (default 2) is left out of the R5 comparison; when nest_i is 0 it takes part.
- R7: In the non-master build (IS_MASTER=0), nest_i has no effect on the outputs.
- R8: When there is no candidate, req_valid_o is 0 and req_idx_o is 0; req_idx_o is also 0 whenever req_valid_o is 0.
- R9: The outputs reflect the inputs sampled at the previous rising clock edge, with exactly one cycle of latency, including a base_i that changes on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pend_i | input | N | Pending request bits |
| mask_i | input | N | Mask bits, 1 blocks the input |
| insvc_i | input | N | In-service bits |
| base_i | input | log2(N) | Input number that holds rank 0 |
| nest_i | input | 1 | Nesting mode, used by the master build only |
| req_valid_o | output | 1 | Registered request flag |
| req_idx_o | output | log2(N) | Registered winning input number, 0 when no request |

## Verification
The assertions assume that every input holds a known binary value at each rising edge from the first edge after reset. They also assume that N is a power of two, so that rank arithmetic wraps in log2(N) bits. Each assertion checks the registered outputs against a copy of the inputs from the previous edge, which is taken inside the checker.

The bench drives all inputs only on falling edges and never leaves one undriven. Its random phase draws the base over its full range and covers dense and sparse vectors. The directed cases hit the strict-comparison tie, the excluded cascade bit and a base that changes every cycle.

// File: rtl/rrp_pkg.sv
package rrp_pkg;
  localparam int unsigned RRP_N_DEF       = 8;
  localparam int unsigned RRP_CASCADE_DEF = 2;
  localparam bit          RRP_MASTER_DEF  = 1'b1;
endpackage

// File: rtl/rrp_rotate.sv
// out[k] = in[(k + sh) mod N]: position k of the output holds rank k
module rrp_rotate #(
  parameter int unsigned N  = 8,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  input  logic [IW-1:0] sh_i,
  output logic [N-1:0]  vec_o
);
  logic [2*N-1:0] dbl;
  logic [2*N-1:0] shifted;

  assign dbl     = {vec_i, vec_i};
  assign shifted = dbl >> sh_i;

  for (genvar k = 0; k < N; k++) begin : g_bit
    assign vec_o[k] = shifted[k];
  end
endmodule

// File: rtl/rrp_lead_find.sv
// Lowest set position; returns N for an empty vector
module rrp_lead_find #(
  parameter int unsigned N  = 8,
  localparam int unsigned RW = $clog2(N) + 1
) (
  input  logic [N-1:0]  vec_i,
  output logic [RW-1:0] rank_o
);
  always_comb begin
    rank_o = RW'(N);
    for (int k = N - 1; k >= 0; k--) begin
      if (vec_i[k]) rank_o = RW'(k);
    end
  end
endmodule

// File: rtl/rot_prio_resolver.sv
module rot_prio_resolver #(
  parameter int unsigned N           = rrp_pkg::RRP_N_DEF,
  parameter bit          IS_MASTER   = rrp_pkg::RRP_MASTER_DEF,
  parameter int unsigned CASCADE_IDX = rrp_pkg::RRP_CASCADE_DEF,
  localparam int unsigned IW = $clog2(N),
  localparam int unsigned RW = IW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  pend_i,
  input  logic [N-1:0]  mask_i,
  input  logic [N-1:0]  insvc_i,
  input  logic [IW-1:0] base_i,
  input  logic          nest_i,
  output logic          req_valid_o,
  output logic [IW-1:0] req_idx_o
);
  logic [N-1:0]  cand, svc_eff;
  logic [N-1:0]  cand_rot, svc_rot;
  logic [RW-1:0] rank_c, rank_s;
  logic          valid_d;
  logic [IW-1:0] idx_d;

  assign cand = pend_i & ~mask_i;

  if (IS_MASTER) begin : g_master
    always_comb begin
      svc_eff = insvc_i;
      if (nest_i) svc_eff[CASCADE_IDX] = 1'b0;
    end
  end else begin : g_slave
    logic unused_nest;
    assign unused_nest = nest_i;
    assign svc_eff     = insvc_i;
  end

  rrp_rotate #(.N(N)) u_rot_cand (.vec_i(cand),    .sh_i(base_i), .vec_o(cand_rot));
  rrp_rotate #(.N(N)) u_rot_svc  (.vec_i(svc_eff), .sh_i(base_i), .vec_o(svc_rot));

  rrp_lead_find #(.N(N)) u_find_cand (.vec_i(cand_rot), .rank_o(rank_c));
  rrp_lead_find #(.N(N)) u_find_svc  (.vec_i(svc_rot),  .rank_o(rank_s));

  // empty candidate gives rank N, never below rank_s
  assign valid_d = rank_c < rank_s;
  assign idx_d   = valid_d ? (rank_c[IW-1:0] + base_i) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_valid_o <= 1'b0;
      req_idx_o   <= '0;
    end else begin
      req_valid_o <= valid_d;
      req_idx_o   <= idx_d;
    end
  end
endmodule

// File: rtl/rrp_checker.sv
module rrp_checker #(
  parameter int unsigned N           = 8,
  parameter bit          IS_MASTER   = 1'b1,
  parameter int unsigned CASCADE_IDX = 2,
  localparam int unsigned IW = $clog2(N)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [N-1:0]  pend_i,
  input logic [N-1:0]  mask_i,
  input logic [N-1:0]  insvc_i,
  input logic [IW-1:0] base_i,
  input logic          nest_i,
  input logic          req_valid_o,
  input logic [IW-1:0] req_idx_o
);
  logic [N-1:0]  p_cand, p_svc;
  logic [IW-1:0] p_base;
  logic          p_nest;
  logic          svc_blocks, cand_beats;
  logic [IW-1:0] win_rank;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_cand <= '0;
      p_svc  <= '0;
      p_base <= '0;
      p_nest <= 1'b0;
    end else begin
      p_cand <= pend_i & ~mask_i;
      p_svc  <= insvc_i;
      p_base <= base_i;
      p_nest <= nest_i;
    end
  end

  always_comb begin
    win_rank   = req_idx_o - p_base;
    svc_blocks = 1'b0;
    cand_beats = 1'b0;
    for (int j = 0; j < N; j++) begin
      if (p_svc[j] && (IW'(j) - p_base) <= win_rank &&
          !(IS_MASTER && p_nest && j == CASCADE_IDX))
        svc_blocks = 1'b1;
      if (p_cand[j] && (IW'(j) - p_base) < win_rank)
        cand_beats = 1'b1;
    end
  end

  assert_winner_is_cand_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> p_cand[req_idx_o]);

  assert_winner_best_rank_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> !cand_beats);

  // covers R6 too: the excluded cascade bit never blocks
  assert_strict_over_svc_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> !svc_blocks);

  assert_empty_no_req_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (p_cand == '0) |-> !req_valid_o);

  assert_idle_idx_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_o |-> (req_idx_o == '0));
endmodule

bind rot_prio_resolver rrp_checker #(
  .N(N), .IS_MASTER(IS_MASTER), .CASCADE_IDX(CASCADE_IDX)
) u_chk (.*);

// File: tb/rot_prio_resolver_tb.sv
module rot_prio_resolver_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  pend = '0, mask = '0, insvc = '0;
  logic [IW-1:0] base = '0;
  logic          nest = 1'b0;
  logic          vm, vs;
  logic [IW-1:0] im, is_;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int exp_vm = 0, exp_im = 0, exp_vs = 0, exp_is = 0;
  string cur_tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  rot_prio_resolver #(.N(N), .IS_MASTER(1'b1), .CASCADE_IDX(2)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pend_i(pend), .mask_i(mask), .insvc_i(insvc),
    .base_i(base), .nest_i(nest), .req_valid_o(vm), .req_idx_o(im));

  rot_prio_resolver #(.N(N), .IS_MASTER(1'b0), .CASCADE_IDX(2)) u_dut_slave (
    .clk_i(clk), .rst_ni(rst_n), .pend_i(pend), .mask_i(mask), .insvc_i(insvc),
    .base_i(base), .nest_i(nest), .req_valid_o(vs), .req_idx_o(is_));

  // behavioural model: walk ranks from the base
  function automatic void model(input bit master, output int v, output int idx);
    int best_c = 8, best_s = 8;
    for (int r = 7; r >= 0; r--) begin
      int i = (r + base) % 8;
      if (pend[i] && !mask[i]) best_c = r;
      if (insvc[i] && !(master && nest && i == 2)) best_s = r;
    end
    v   = (best_c < best_s) ? 1 : 0;
    idx = v ? (best_c + base) % 8 : 0;
  endfunction

  task automatic check_now();
    n_chk++;
    if (int'(vm) != exp_vm || int'(im) != exp_im) begin
      n_fail++;
      $display("FAIL %s master: valid=%0d idx=%0d expected valid=%0d idx=%0d",
               cur_tag, vm, im, exp_vm, exp_im);
    end
    n_chk++;
    if (int'(vs) != exp_vs || int'(is_) != exp_is) begin
      n_fail++;
      $display("FAIL %s slave: valid=%0d idx=%0d expected valid=%0d idx=%0d",
               cur_tag, vs, is_, exp_vs, exp_is);
    end
  endtask

  // drive at a falling edge, check at the next falling edge (one register)
  task automatic step(input logic [7:0] p, input logic [7:0] m, input logic [7:0] s,
                      input logic [2:0] b, input logic n, input string tag);
    pend = p; mask = m; insvc = s; base = b; nest = n;
    model(1'b1, exp_vm, exp_im);
    model(1'b0, exp_vs, exp_is);
    cur_tag = tag;
    @(negedge clk);
    check_now();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    // R1: reset state while reset held, with live inputs
    pend = 8'hFF;
    repeat (2) @(negedge clk);
    cur_tag = "R1";
    check_now();
    rst_n = 1'b1;
    pend = '0;
    @(negedge clk);
    check_now();

    // R2: masking
    step(8'h01, 8'h01, 8'h00, 3'd0, 1'b0, "R2");
    step(8'h03, 8'h01, 8'h00, 3'd0, 1'b0, "R2");
    step(8'hFF, 8'hFE, 8'h00, 3'd3, 1'b0, "R2");
    // R3: rotated ranking
    step(8'h29, 8'h00, 8'h00, 3'd5, 1'b0, "R3");
    step(8'h21, 8'h00, 8'h00, 3'd6, 1'b0, "R3");
    step(8'h06, 8'h00, 8'h00, 3'd2, 1'b0, "R3");
    // R4: absolute index returned
    step(8'h80, 8'h00, 8'h00, 3'd7, 1'b0, "R4");
    step(8'h40, 8'h00, 8'h00, 3'd7, 1'b0, "R4");
    // R5: strict comparison against in-service
    step(8'h10, 8'h00, 8'h10, 3'd0, 1'b0, "R5");
    step(8'h10, 8'h00, 8'h20, 3'd0, 1'b0, "R5");
    step(8'h10, 8'h00, 8'h08, 3'd0, 1'b0, "R5");
    step(8'h01, 8'h00, 8'h80, 3'd1, 1'b0, "R5");
    // R6 / R7: cascade bit excluded only on the master with nesting on
    step(8'h08, 8'h00, 8'h04, 3'd0, 1'b1, "R6");
    step(8'h08, 8'h00, 8'h04, 3'd0, 1'b0, "R6");
    step(8'h04, 8'h00, 8'h04, 3'd0, 1'b1, "R6");
    step(8'h08, 8'h00, 8'h06, 3'd0, 1'b1, "R7");
    // R8: no candidate
    step(8'h00, 8'h00, 8'h00, 3'd4, 1'b0, "R8");
    step(8'hF0, 8'hF0, 8'h00, 3'd4, 1'b1, "R8");
    // R9: base changes every cycle
    step(8'h11, 8'h00, 8'h00, 3'd0, 1'b0, "R9");
    step(8'h11, 8'h00, 8'h00, 3'd2, 1'b0, "R9");
    step(8'h11, 8'h00, 8'h00, 3'd5, 1'b0, "R9");
    step(8'h11, 8'h00, 8'h00, 3'd1, 1'b0, "R9");

    for (int k = 0; k < 4000; k++) begin
      logic [7:0] p, m, s;
      p = 8'($urandom);
      m = (k % 3 == 0) ? 8'h00 : 8'($urandom) & 8'($urandom);
      s = (k % 4 == 0) ? 8'h00 : 8'($urandom) & 8'($urandom);
      step(p, m, s, 3'($urandom), 1'($urandom), "R3");
    end
    finish_run();
  end
endmodule